// File: doc/BRIEF.md
# Replay Input Event Logger

This block sits beside a processor core and writes down the inputs that a later full-system replay cannot work out for itself. There are three of them. The first is an asynchronous interrupt, recorded with its type number. The second is the value returned by a programmed I/O load. The third is each data word that DMA writes into memory. Every record carries a 32-bit stamp. Interrupts and I/O loads are stamped with the number of instructions the processor committed before the event. DMA words are treated as a separate pseudo-thread and are stamped with their own sequence number. Synchronous exceptions and I/O stores leave no trace, because replay reproduces them.

Records enter a small queue and leave through a valid/ready stream. At most three events can arrive in one cycle. They are queued in a fixed order: interrupt, then I/O load, then DMA. If the stream stalls and an event finds no free slot, that event is dropped and a sticky overflow flag is set. When slots run short within one cycle, the lowest-priority events are the ones dropped.

Top module: `evlog_top`

## Requirements
- R1: After reset `logValid` and `overflow` are 0, and both the instruction count and the DMA sequence count start from 0.
- R2: An interrupt strobe produces a record with `logRecord[65:64]` = 2'b00, `logRecord[63:32]` = the number of `retireInst` pulses seen in earlier cycles, and `logRecord[31:0]` = `irqType` zero-extended.
- R3: An `excValid` strobe on its own produces no record. An I/O load flagged in the same cycle as `excValid` also produces no record.
- R4: An I/O load (`ioValid` with `ioIsLoad`=1) produces a record with type 2'b01, the instruction-count stamp, and `ioData` as the payload.
- R5: An I/O store (`ioValid` with `ioIsLoad`=0) produces no record.
- R6: A DMA strobe produces a record with type 2'b10, a stamp equal to the number of DMA strobes in earlier cycles since reset, and `dmaData` as the payload. The sequence number advances on every DMA strobe, including strobes that are dropped.
- R7: Events that arrive in the same cycle leave in the order interrupt, then I/O load, then DMA. Records from different cycles leave in the order of their arrival cycles.
- R8: While `logValid` is high and `logReady` is low, `logRecord` holds its value. Each cycle with both high removes exactly one record.
- R9: Up to DEPTH records are held while the stream is stalled, and none of them is lost.
- R10: An event that finds no free slot is dropped, lowest priority first. A drop sets `overflow`, which then stays high until reset.
- R11: When the queue is empty, a record appears on `logValid`/`logRecord` in the cycle after its event strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireInst | input | 1 | One instruction committed this cycle |
| irqValid | input | 1 | Asynchronous interrupt taken this cycle |
| irqType | input | IRQ_W | Interrupt type number |
| excValid | input | 1 | Synchronous exception this cycle |
| ioValid | input | 1 | Programmed I/O access completes |
| ioIsLoad | input | 1 | 1 = load, 0 = store |
| ioData | input | 32 | Value returned by the I/O load |
| dmaValid | input | 1 | DMA writes one word to memory |
| dmaData | input | 32 | DMA data word |
| logValid | output | 1 | Record available |
| logReady | input | 1 | Consumer accepts the record |
| logRecord | output | 66 | {type[1:0], stamp[31:0], payload[31:0]} |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The assertions assume a few things about the environment. `retireInst` pulses at most once per cycle. Each source raises at most one event per cycle. DEPTH is a power of two and at least 2. The consumer may hold `logReady` low for any length of time. The stimulus keeps to these limits by driving every strobe as a single-cycle level set between clock edges, with at most one event per source in each cycle. Stalls use the same mechanism: `logReady` is held low across many cycles while the queue is filled past DEPTH.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  parameter int STAMP_W = 32;
  parameter int DATA_W  = 32;

  typedef enum logic [1:0] {
    KIND_IRQ  = 2'b00,
    KIND_IOLD = 2'b01,
    KIND_DMA  = 2'b10,
    KIND_RSVD = 2'b11
  } recKind_e;

  typedef struct packed {
    recKind_e            kind;
    logic [STAMP_W-1:0]  stamp;
    logic [DATA_W-1:0]   payload;
  } logRec_t;

  localparam int REC_W = $bits(logRec_t);

  typedef struct packed {
    logic takeIrq;
    logic takeIo;
    logic takeDma;
    logic pop;
  } logStrobe_t;
endpackage

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
  import evlog_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqValid,
  input  logic       excValid,
  input  logic       ioValid,
  input  logic       ioIsLoad,
  input  logic       dmaValid,
  input  logic       logReady,
  output logStrobe_t strb,
  output logic       logValid,
  output logic       overflow
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ;
  logic [OCC_W:0]   room;
  logic [OCC_W:0]   used;
  logic             irqReq, ioReq, dmaReq;
  logic             pop;
  logic             dropAny;

  // A faulting I/O load returns nothing, so replay re-raises the exception (R3)
  assign irqReq = irqValid;
  assign ioReq  = ioValid && ioIsLoad && !excValid;
  assign dmaReq = dmaValid;

  assign logValid = (occ != '0);
  assign pop      = logValid && logReady;
  assign room     = (OCC_W+1)'(DEPTH) - {1'b0, occ} + (OCC_W+1)'(pop);

  // Slots are handed out in priority order within one cycle (R7, R10)
  always_comb begin
    used         = '0;
    strb.takeIrq = irqReq && (room > used);
    used         = used + (OCC_W+1)'(strb.takeIrq);
    strb.takeIo  = ioReq && (room > used);
    used         = used + (OCC_W+1)'(strb.takeIo);
    strb.takeDma = dmaReq && (room > used);
    used         = used + (OCC_W+1)'(strb.takeDma);
    strb.pop     = pop;
  end

  assign dropAny = (irqReq && !strb.takeIrq) || (ioReq && !strb.takeIo) ||
                   (dmaReq && !strb.takeDma);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ      <= '0;
      overflow <= 1'b0;
    end else begin
      occ      <= occ + OCC_W'(used) - OCC_W'(pop);
      overflow <= overflow || dropAny;
    end
  end

  p_occ_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !logReady) |=> logValid);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_raise_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(dropAny));

  p_priority_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeDma && ioReq) |-> strb.takeIo);

  p_no_record_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid && !dmaValid && (excValid || (ioValid && !ioIsLoad))) |=> occ <= $past(occ));
endmodule

// File: rtl/evlog_dpath.sv
module evlog_dpath
  import evlog_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        strb,
  input  logic              retireInst,
  input  logic              dmaValid,
  input  logic [IRQ_W-1:0]  irqType,
  input  logic [DATA_W-1:0] ioData,
  input  logic [DATA_W-1:0] dmaData,
  output logRec_t           headRec
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [STAMP_W-1:0] instrCnt;
  logic [STAMP_W-1:0] dmaSeq;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [PTR_W-1:0]   ioSlot, dmaSlot;
  logRec_t            slots [DEPTH];
  logRec_t            irqRec, ioRec, dmaRec;
  logic [1:0]         nTaken;

  assign irqRec  = '{kind: KIND_IRQ,  stamp: instrCnt, payload: DATA_W'(irqType)};
  assign ioRec   = '{kind: KIND_IOLD, stamp: instrCnt, payload: ioData};
  assign dmaRec  = '{kind: KIND_DMA,  stamp: dmaSeq,   payload: dmaData};

  assign ioSlot  = wrPtr + PTR_W'(strb.takeIrq);
  assign dmaSlot = ioSlot + PTR_W'(strb.takeIo);
  assign nTaken  = 2'(strb.takeIrq) + 2'(strb.takeIo) + 2'(strb.takeDma);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrCnt <= '0;
      dmaSeq   <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      if (retireInst) instrCnt <= instrCnt + 1'b1;
      if (dmaValid)   dmaSeq   <= dmaSeq + 1'b1;
      wrPtr <= wrPtr + PTR_W'(nTaken);
      if (strb.pop) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.takeIrq) slots[wrPtr]   <= irqRec;
    if (strb.takeIo)  slots[ioSlot]  <= ioRec;
    if (strb.takeDma) slots[dmaSlot] <= dmaRec;
  end

  assign headRec = slots[rdPtr];

  p_stamp_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !retireInst |=> $stable(instrCnt));

  p_dma_seq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dmaValid |=> $stable(dmaSeq));
endmodule

// File: rtl/evlog_top.sv
module evlog_top
  import evlog_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IRQ_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireInst,
  input  logic              irqValid,
  input  logic [IRQ_W-1:0]  irqType,
  input  logic              excValid,
  input  logic              ioValid,
  input  logic              ioIsLoad,
  input  logic [31:0]       ioData,
  input  logic              dmaValid,
  input  logic [31:0]       dmaData,
  output logic              logValid,
  input  logic              logReady,
  output logic [65:0]       logRecord,
  output logic              overflow
);
  logStrobe_t strb;
  logRec_t    headRec;

  evlog_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .irqValid(irqValid), .excValid(excValid),
    .ioValid(ioValid), .ioIsLoad(ioIsLoad),
    .dmaValid(dmaValid), .logReady(logReady),
    .strb(strb), .logValid(logValid), .overflow(overflow)
  );

  evlog_dpath #(.DEPTH(DEPTH), .IRQ_W(IRQ_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .retireInst(retireInst), .dmaValid(dmaValid),
    .irqType(irqType), .ioData(ioData), .dmaData(dmaData),
    .headRec(headRec)
  );

  assign logRecord = headRec;

  p_record_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !logReady) |=> $stable(logRecord));

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    logValid |-> (logRecord[65:64] != 2'b11));
endmodule

// File: tb/evlog_top_test.sv
module evlog_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireInst, irqValid, excValid, ioValid, ioIsLoad, dmaValid, logReady;
  logic [7:0]  irqType;
  logic [31:0] ioData, dmaData;
  logic        logValid, overflow;
  logic [65:0] logRecord;

  evlog_top #(.DEPTH(DEPTH), .IRQ_W(8)) uut (
    .clk(clk), .rstN(rstN), .retireInst(retireInst),
    .irqValid(irqValid), .irqType(irqType), .excValid(excValid),
    .ioValid(ioValid), .ioIsLoad(ioIsLoad), .ioData(ioData),
    .dmaValid(dmaValid), .dmaData(dmaData),
    .logValid(logValid), .logReady(logReady), .logRecord(logRecord),
    .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [65:0] expQ[$];
  int unsigned icnt, dseq;
  bit          ovfM;
  int          checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareOut(input string req);
    check(logValid === (expQ.size() != 0), req, "logValid",
          66'(logValid), 66'(expQ.size() != 0));
    if (expQ.size() != 0)
      check(logRecord === expQ[0], req, "logRecord", logRecord, expQ[0]);
    check(overflow === ovfM, req, "overflow", 66'(overflow), 66'(ovfM));
  endtask

  task automatic clearIn();
    retireInst = 0; irqValid = 0; irqType = 0; excValid = 0;
    ioValid = 0; ioIsLoad = 0; ioData = 0; dmaValid = 0; dmaData = 0;
  endtask

  // One clock cycle of stimulus, called at a falling edge
  task automatic step(input bit ret, input bit irq, input logic [7:0] it,
                      input bit exc, input bit io, input bit ld, input logic [31:0] iod,
                      input bit dma, input logic [31:0] dd, input bit rdy,
                      input string req);
    logic [65:0] pend[$];
    int room;
    retireInst = ret; irqValid = irq; irqType = it; excValid = exc;
    ioValid = io; ioIsLoad = ld; ioData = iod; dmaValid = dma; dmaData = dd;
    logReady = rdy;
    room = DEPTH - expQ.size() + ((expQ.size() != 0 && rdy) ? 1 : 0);
    if (irq) pend.push_back({2'b00, icnt, 24'h0, it});
    if (io && ld && !exc) pend.push_back({2'b01, icnt, iod});
    if (dma) pend.push_back({2'b10, dseq, dd});
    @(posedge clk);
    if (expQ.size() != 0 && rdy) void'(expQ.pop_front());
    foreach (pend[k]) begin
      if (k < room) expQ.push_back(pend[k]);
      else ovfM = 1;
    end
    if (ret) icnt++;
    if (dma) dseq++;
    @(negedge clk);
    clearIn();
    compareOut(req);
  endtask

  task automatic idle(input bit rdy, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, rdy, req);
  endtask

  task automatic drain(input string req);
    while (expQ.size() != 0) idle(1, req);
    idle(1, req);
  endtask

  task automatic doReset();
    clearIn();
    logReady = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    expQ.delete(); icnt = 0; dseq = 0; ovfM = 0;
    check(logValid === 1'b0, "R1", "logValid after reset", 66'(logValid), 66'(0));
    check(overflow === 1'b0, "R1", "overflow after reset", 66'(overflow), 66'(0));
  endtask

  task automatic testResetStamps();
    // R1: first interrupt and first DMA both carry stamp 0
    step(0, 1, 8'h11, 0, 0, 0, 0, 1, 32'hA0A0_0001, 1, "R1");
    drain("R1");
  endtask

  task automatic testInterrupt();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    // retire in the same cycle does not count toward this stamp (R2)
    step(1, 1, 8'h2A, 0, 0, 0, 0, 0, 0, 1, "R2");
    drain("R2");
  endtask

  task automatic testIgnored();
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 1, 1, 1, 32'hDEAD_0003, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 1, 0, 32'hBEEF_0005, 0, 0, 1, "R5");
    idle(1, "R5");
  endtask

  task automatic testIoLoad();
    step(1, 0, 0, 0, 1, 1, 32'h1234_5678, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 1, 1, 32'h0BAD_F00D, 0, 0, 1, "R11");
    drain("R4");
  endtask

  task automatic testDma();
    for (int i = 0; i < 3; i++)
      step(i[0], 0, 0, 0, 0, 0, 0, 1, 32'hD000_0000 + 32'(i), 1, "R6");
    drain("R6");
  endtask

  task automatic testSameCycle();
    step(0, 1, 8'h07, 0, 1, 1, 32'h1111_2222, 1, 32'h3333_4444, 0, "R7");
    step(1, 0, 0, 0, 1, 1, 32'h5555_6666, 1, 32'h7777_8888, 0, "R7");
    for (int i = 0; i < 3; i++) idle(0, "R8");
    drain("R7");
  endtask

  task automatic testFill();
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, 0, 0, 0, 0, 1, 32'hF000_0000 + 32'(i), 0, "R9");
    idle(0, "R9");
    drain("R9");
  endtask

  task automatic testOverflow();
    for (int i = 0; i < 3; i++)
      step(0, 1, 8'(i), 0, 1, 1, 32'hC000_0000 + 32'(i), 1, 32'hE000_0000 + 32'(i), 0, "R10");
    step(0, 1, 8'h55, 0, 0, 0, 0, 0, 0, 0, "R10");
    // pop and push in one cycle while full: one slot frees up
    step(0, 1, 8'h66, 0, 0, 0, 0, 1, 32'hE000_00FF, 1, "R10");
    drain("R10");
    idle(1, "R10");
    doReset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    testResetStamps();
    testInterrupt();
    testIgnored();
    testIoLoad();
    testDma();
    testSameCycle();
    testFill();
    testOverflow();
    testInterrupt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule